// File: doc/BRIEF.md
# Sectored Flash Command Controller

This block sits between an 8-bit microcontroller bus and a sectored Flash array. It decodes bus writes into commands and runs a small state machine. Outside a command sequence, reads return the array byte at the requested address. A three-write unlock prefix selects one of three commands: a sector-protection query, a byte program or a sector erase. The program and erase algorithms themselves are not built here. A busy counter stands in for them, and while it runs, reads return a status byte instead of array data. Writes are dropped while the supply-lockout input is high, and a reset command returns the machine to plain reads.

Bus requests arrive on a valid/ready channel. A read produces one response on a valid/ready response channel. Only one read response can be outstanding. While a response is held and `rsp_ready` is low, `req_ready` stays low, so no new request of either kind is taken. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Writes produce no response. Array read data is sampled at the acceptance edge from `arr_rd_data`, which must combinationally follow `arr_rd_addr`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset no response is pending, `req_ready` is high and the controller is in read mode, where an accepted read returns `arr_rd_data` for its address.
- R2: While `supply_low` is 1, every accepted write is ignored and changes no state.
- R3: The writes 0xAA to address 0x555, 0x55 to address 0x0AA and 0x90 to address 0x555, in that order, enter the protection-query state.
- R4: In the query state, a read whose address has bit 6 = 0, bit 1 = 1 and bit 0 = 0 returns 0x01 if any sector flagged in `req_sel` has its `sect_prot` bit set, and 0x00 otherwise. After this one read the controller is in read mode again.
- R5: In the query state, a read that fails the address-bit check returns 0xFF and also returns the controller to read mode.
- R6: The same prefix followed by 0xA0 to address 0x555 arms a program. The next write then pulses `arr_pgm` for one cycle, one cycle after acceptance, with its address, data and select, and starts a busy period of PGM_CYCLES. The prefix followed by 0x80 to address 0x555 arms an erase. A following write of 0x30 pulses `arr_ers` and starts a busy period of ERS_CYCLES. If the selected sector is protected, or the erase confirm byte is wrong, no pulse is issued and the controller returns to read mode.
- R7: Let the starting write be accepted at edge k and the busy length be N. A read accepted at any edge from k+1 to k+N returns a status byte, and a read accepted from edge k+N+1 on returns array data. In the status byte, bit 7 is 0 (not done), bit 6 is a toggle that is 0 on the first read of the operation and inverts on each later read, bit 3 is 1 for an erase, and all other bits are 0. Writes accepted during the busy period are ignored.
- R8: A write that does not match the next expected step of a sequence returns the controller to read mode.
- R9: A response becomes valid in the cycle after its read is accepted. `rsp_valid` and `rsp_data` then hold until `rsp_ready` is high at an edge, and `req_ready` is low while a response is held without `rsp_ready`.
- R10: Reads accepted between the writes of an unfinished sequence return array data and do not disturb the sequence.
- R11: A write of 0xF0, at any address and outside a busy period, is the reset command and returns the controller to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| req_sel | input | NSECT | Sector select, one bit per sector |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 8 | Read response byte |
| arr_rd_addr | output | ADDR_W | Array read address, follows req_addr |
| arr_rd_data | input | 8 | Array read byte for arr_rd_addr |
| arr_pgm | output | 1 | One-cycle program start pulse |
| arr_ers | output | 1 | One-cycle erase start pulse |
| arr_wr_addr | output | ADDR_W | Address of the started operation |
| arr_wr_data | output | 8 | Data byte of the started program |
| arr_sel | output | NSECT | Sector select of the started operation |
| supply_low | input | 1 | Supply below lockout threshold; writes ignored |
| sect_prot | input | NSECT | Per-sector protection flags |

## Verification
Every read response is due in the cycle after its acceptance edge. The bench samples it at the falling edge that follows and then holds `rsp_ready` low for a random number of cycles to test that the response stays stable. Start pulses for program and erase are due at that same falling edge after the starting write. For status versus array data, the bench counts rising edges and records the acceptance edge of every request. The model then classifies each read as status when its edge falls in the busy window from k+1 to k+N, so the end of each operation is checked to the exact cycle.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_QRY,
    ST_PGM_ARM,
    ST_ERS_ARM,
    ST_BUSY
  } fcc_state_e;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  OP_QUERY   = 8'h90;
  localparam logic [7:0]  OP_PROGRAM = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  ERASE_GO   = 8'h30;
  localparam logic [7:0]  OP_RESET   = 8'hF0;

  localparam logic [10:0] KEY_ADR_A  = 11'h555;
  localparam logic [10:0] KEY_ADR_B  = 11'h0AA;

  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_TOG_BIT  = 6;
  localparam int STAT_ERS_BIT  = 3;

  localparam logic [7:0] QRY_BAD = 8'hFF;

endpackage

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
  parameter int PGM_CYCLES = 12,
  parameter int ERS_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase,
  output logic busy,
  output logic expire
);
  localparam int MAXC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= erase ? CW'(ERS_CYCLES) : CW'(PGM_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy   = (cnt != '0);
  assign expire = (cnt == CW'(1));

  // R7: busy length is loaded from the operation kind
  a_r7_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == ($past(erase) ? CW'(ERS_CYCLES) : CW'(PGM_CYCLES)));

  // R7: a running window shrinks by one per cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NSECT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [NSECT-1:0]  sel,
  input  logic              supply_low,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              tmr_expire,
  output logic              tmr_start,
  output logic              tmr_erase,
  output logic              rd_from_array,
  output logic [7:0]        rd_byte,
  output fcc_state_e        state_o,
  output logic              arr_pgm,
  output logic              arr_ers,
  output logic [ADDR_W-1:0] arr_wr_addr,
  output logic [7:0]        arr_wr_data,
  output logic [NSECT-1:0]  arr_sel
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADR_B);

  fcc_state_e state, nxt;
  logic       tog, ers_flag;
  logic       prot_hit, qual_ok, wr_live;
  logic       go_pgm, go_ers;

  assign prot_hit = |(sel & sect_prot);
  assign qual_ok  = !addr[6] && addr[1] && !addr[0];
  assign wr_live  = wr_acc && !supply_low && (state != ST_BUSY);

  always_comb begin
    nxt    = state;
    go_pgm = 1'b0;
    go_ers = 1'b0;
    if (state == ST_BUSY && tmr_expire) nxt = ST_READ;
    if (wr_live) begin
      if (wdata == OP_RESET) begin
        nxt = ST_READ;
      end else begin
        unique case (state)
          ST_READ:  nxt = (addr == ADR_A && wdata == KEY_FIRST) ? ST_UNL1 : ST_READ;
          ST_UNL1:  nxt = (addr == ADR_B && wdata == KEY_SECOND) ? ST_UNL2 : ST_READ;
          ST_UNL2: begin
            nxt = ST_READ;
            if (addr == ADR_A) begin
              if (wdata == OP_QUERY)   nxt = ST_QRY;
              if (wdata == OP_PROGRAM) nxt = ST_PGM_ARM;
              if (wdata == OP_ERASE)   nxt = ST_ERS_ARM;
            end
          end
          ST_PGM_ARM: begin
            go_pgm = !prot_hit;
            nxt    = prot_hit ? ST_READ : ST_BUSY;
          end
          ST_ERS_ARM: begin
            go_ers = !prot_hit && (wdata == ERASE_GO);
            nxt    = go_ers ? ST_BUSY : ST_READ;
          end
          default: nxt = ST_READ;
        endcase
      end
    end else if (rd_acc && state == ST_QRY) begin
      nxt = ST_READ;
    end
  end

  assign tmr_start = go_pgm || go_ers;
  assign tmr_erase = go_ers;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_READ;
      tog         <= 1'b0;
      ers_flag    <= 1'b0;
      arr_pgm     <= 1'b0;
      arr_ers     <= 1'b0;
      arr_wr_addr <= '0;
      arr_wr_data <= '0;
      arr_sel     <= '0;
    end else begin
      state   <= nxt;
      arr_pgm <= go_pgm;
      arr_ers <= go_ers;
      if (tmr_start) begin
        tog         <= 1'b0;
        ers_flag    <= go_ers;
        arr_wr_addr <= addr;
        arr_wr_data <= wdata;
        arr_sel     <= sel;
      end else if (rd_acc && state == ST_BUSY) begin
        tog <= ~tog;
      end
    end
  end

  always_comb begin
    rd_from_array = 1'b1;
    rd_byte       = '0;
    if (state == ST_BUSY) begin
      rd_from_array              = 1'b0;
      rd_byte[STAT_DONE_BIT]     = 1'b0;
      rd_byte[STAT_TOG_BIT]      = tog;
      rd_byte[STAT_ERS_BIT]      = ers_flag;
    end else if (state == ST_QRY) begin
      rd_from_array = 1'b0;
      rd_byte       = qual_ok ? {7'b0, prot_hit} : QRY_BAD;
    end
  end

  assign state_o = state;

  // R2: a write under supply lockout leaves the command state alone
  a_r2_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && supply_low && state != ST_BUSY) |=> $stable(state));

  // R7: writes during a busy period do not leave it early
  a_r7_busy_ignores_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && wr_acc && !tmr_expire) |=> state == ST_BUSY);

  // R4: exactly one read is served in query state
  a_r4_query_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QRY && rd_acc) |=> state == ST_READ);

  // R6: protected sector never sees a program pulse
  a_r6_prot_no_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PGM_ARM && wr_acc && !supply_low && prot_hit && wdata != OP_RESET)
      |=> !arr_pgm && state == ST_READ);

  // R6: start pulses are exclusive
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_pgm, arr_ers}));

endmodule

// File: rtl/fcc_rsp_stage.sv
module fcc_rsp_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_acc,
  input  logic [7:0] rd_data,
  input  logic       rsp_ready,
  output logic       req_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: an untaken response holds value
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  // R9: accepted read yields a response next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NSECT      = 8,
  parameter int PGM_CYCLES = 12,
  parameter int ERS_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [NSECT-1:0]  req_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [7:0]        arr_rd_data,
  output logic              arr_pgm,
  output logic              arr_ers,
  output logic [ADDR_W-1:0] arr_wr_addr,
  output logic [7:0]        arr_wr_data,
  output logic [NSECT-1:0]  arr_sel,
  input  logic              supply_low,
  input  logic [NSECT-1:0]  sect_prot
);
  logic       acc, wr_acc, rd_acc;
  logic       tmr_start, tmr_erase, tmr_busy, tmr_expire;
  logic       rd_from_array;
  logic [7:0] rd_byte, rd_data;
  fcc_state_e state;

  assign acc         = req_valid && req_ready;
  assign wr_acc      = acc && req_write;
  assign rd_acc      = acc && !req_write;
  assign arr_rd_addr = req_addr;
  assign rd_data     = rd_from_array ? arr_rd_data : rd_byte;

  fcc_decoder #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_dec (
    .clk, .rst_n, .wr_acc, .rd_acc,
    .addr(req_addr), .wdata(req_wdata), .sel(req_sel),
    .supply_low, .sect_prot, .tmr_expire,
    .tmr_start, .tmr_erase, .rd_from_array, .rd_byte,
    .state_o(state),
    .arr_pgm, .arr_ers, .arr_wr_addr, .arr_wr_data, .arr_sel
  );

  fcc_busy_timer #(.PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)) u_tmr (
    .clk, .rst_n, .start(tmr_start), .erase(tmr_erase),
    .busy(tmr_busy), .expire(tmr_expire)
  );

  fcc_rsp_stage u_rsp (
    .clk, .rst_n, .rd_acc, .rd_data, .rsp_ready,
    .req_ready, .rsp_valid, .rsp_data
  );

  // R7: status mode and the busy counter agree
  a_r7_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) == tmr_busy);

  // R9: no acceptance while a response is stuck
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int AW = 12, NS = 8, PC = 12, EC = 40;
  localparam int M_READ = 0, M_UNL1 = 1, M_UNL2 = 2, M_QRY = 3,
                 M_PGM = 4, M_ERS = 5, M_BUSY = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0, supply_low = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [NS-1:0] req_sel = 8'h01, sect_prot = '0;
  logic req_ready, rsp_valid, arr_pgm, arr_ers;
  logic [7:0] rsp_data, arr_rd_data, arr_wr_data;
  logic [AW-1:0] arr_rd_addr, arr_wr_addr;
  logic [NS-1:0] arr_sel;
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  int m_st = M_READ, m_start = 0, m_len = 0;
  bit m_ers = 0, m_tog = 0;

  flash_cmd_ctrl #(.ADDR_W(AW), .NSECT(NS), .PGM_CYCLES(PC), .ERS_CYCLES(EC)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .req_sel, .rsp_valid, .rsp_ready, .rsp_data, .arr_rd_addr, .arr_rd_data,
    .arr_pgm, .arr_ers, .arr_wr_addr, .arr_wr_data, .arr_sel, .supply_low, .sect_prot);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] arr_val(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]};
  endfunction
  assign arr_rd_data = arr_val(arr_rd_addr);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic void m_expire(input int acc);
    if (m_st == M_BUSY && acc > m_start + m_len) m_st = M_READ;
  endfunction

  function automatic void m_write(input logic [AW-1:0] a, input logic [7:0] d, input int acc);
    bit hit;
    hit = |(req_sel & sect_prot);
    m_expire(acc);
    if (supply_low || m_st == M_BUSY) return;
    if (d == 8'hF0) begin m_st = M_READ; return; end
    case (m_st)
      M_READ: m_st = (a == 12'h555 && d == 8'hAA) ? M_UNL1 : M_READ;
      M_UNL1: m_st = (a == 12'h0AA && d == 8'h55) ? M_UNL2 : M_READ;
      M_UNL2: m_st = (a != 12'h555) ? M_READ : (d == 8'h90) ? M_QRY :
                     (d == 8'hA0) ? M_PGM : (d == 8'h80) ? M_ERS : M_READ;
      M_PGM: if (hit) m_st = M_READ;
             else begin m_st = M_BUSY; m_start = acc; m_len = PC; m_ers = 0; m_tog = 0; end
      M_ERS: if (hit || d != 8'h30) m_st = M_READ;
             else begin m_st = M_BUSY; m_start = acc; m_len = EC; m_ers = 1; m_tog = 0; end
      default: m_st = M_READ;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [AW-1:0] a, input int acc);
    logic [7:0] e;
    m_expire(acc);
    if (m_st == M_BUSY) begin
      e = {1'b0, m_tog, 2'b0, m_ers, 3'b0};
      m_tog = ~m_tog;
    end else if (m_st == M_QRY) begin
      e = (!a[6] && a[1] && !a[0]) ? {7'b0, |(req_sel & sect_prot)} : 8'hFF;
      m_st = M_READ;
    end else e = arr_val(a);
    return e;
  endfunction

  task automatic bus_op(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                        output int acc, output logic [7:0] rdat);
    int hold;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    acc = cyc;
    rdat = '0;
    if (!wr) begin
      chk("R9 rsp_valid after read", {7'b0, rsp_valid}, 8'h01);
      chk("R9 req_ready low while held", {7'b0, req_ready}, 8'h00);
      rdat = rsp_data;
      hold = $urandom % 3;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R9 response held", rsp_valid ? rsp_data : 8'hEE, rdat);
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    int acc; logic [7:0] r;
    bus_op(1, a, d, acc, r);
    m_write(a, d, acc);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    int acc; logic [7:0] r, e;
    bus_op(0, a, 8'h00, acc, r);
    e = m_read(a, acc);
    chk(req, r, e);
  endtask

  task automatic unlock(input logic [7:0] op);
    wr(12'h555, 8'hAA); wr(12'h0AA, 8'h55); wr(12'h555, op);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 no response after reset", {7'b0, rsp_valid}, 8'h00);
    chk("R1 ready after reset", {7'b0, req_ready}, 8'h01);
    rd(12'h123, "R1 plain read");

    sect_prot = 8'h04; req_sel = 8'h04;
    unlock(8'h90); rd(12'h002, "R3 R4 query protected");
    rd(12'h002, "R4 back to read mode");
    req_sel = 8'h01;
    unlock(8'h90); rd(12'h0A6, "R4 query unprotected");
    unlock(8'h90); rd(12'h042, "R5 bad qualifier");
    rd(12'h002, "R5 aborted query");

    wr(12'h555, 8'hAA); wr(12'h0AA, 8'h12); wr(12'h555, 8'h90);
    rd(12'h002, "R8 broken pattern");

    wr(12'h555, 8'hAA); rd(12'h311, "R10 read mid sequence");
    wr(12'h0AA, 8'h55); rd(12'h7F0, "R10 read mid sequence");
    wr(12'h555, 8'h90); rd(12'h002, "R10 query still reached");

    supply_low = 1; unlock(8'h90); supply_low = 0;
    rd(12'h002, "R2 lockout ignored writes");

    unlock(8'h90); wr(12'h3C0, 8'hF0); rd(12'h002, "R11 reset command");

    sect_prot = 8'h00; req_sel = 8'h02;
    unlock(8'hA0); wr(12'h200, 8'h3A);
    chk("R6 program pulse", {7'b0, arr_pgm}, 8'h01);
    chk("R6 program data", arr_wr_data, 8'h3A);
    chk("R6 program addr", arr_wr_addr[7:0], 8'h00);
    rd(12'h200, "R7 status first");
    wr(12'h555, 8'hF0);
    for (int i = 0; i < 8; i++) rd(12'h200, "R7 status repeat");

    sect_prot = 8'h02;
    unlock(8'hA0); wr(12'h200, 8'h11);
    chk("R6 protected no pulse", {7'b0, arr_pgm}, 8'h00);
    rd(12'h200, "R6 protected stays read");

    sect_prot = 8'h00;
    unlock(8'h80); wr(12'h400, 8'h30);
    chk("R6 erase pulse", {7'b0, arr_ers}, 8'h01);
    for (int i = 0; i < 20; i++) rd(12'h400, "R7 erase status");

    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 8;
      req_sel = 8'h01 << ($urandom % 8);
      case (op)
        0, 1, 2: rd(AW'($urandom), "R1 R7 random read");
        3: wr(AW'($urandom), ($urandom % 4 == 0) ? 8'hF0 : 8'($urandom));
        4: begin
             sect_prot = 8'($urandom); unlock(8'h90);
             rd({AW'($urandom)} & 12'hFBF | 12'h002 & ~12'h001 | (($urandom % 3 == 0) ? 12'h041 : 12'h000),
                "R4 R5 random query");
           end
        5: begin sect_prot = 8'($urandom); unlock(8'hA0); wr(AW'($urandom), 8'($urandom)); end
        6: begin sect_prot = 8'($urandom); unlock(8'h80);
             wr(AW'($urandom), ($urandom % 2) ? 8'h30 : 8'h31); end
        default: begin supply_low = 1; wr(12'h555, 8'hAA); supply_low = 0;
             rd(12'h002, "R2 random lockout"); end
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule